// File: doc/BRIEF.md
# Virtual Address Access Checker with Fault Capture

This block decides, for one load, store or instruction fetch per request, whether a 32-bit virtual address may be used and to which physical address it goes. It applies fixed region rules first: with translation switched off every address is its own physical address; privileged code reaches the top quarter of the space untranslated; unprivileged code may not touch the upper half at all. Every other access is judged on a translation lookup result supplied by the caller: a hit entry with the right permission gives a translated address, and anything else gives a fault code.

When a fault is raised (and the request is not a probe), the block records the details a handler needs. It stores the faulting address, and for translation faults it also stores the page-number pointer into the page table and a data-versus-fetch flag. A misaligned access is caught before all other rules and also loads an exception-cause register. A probe request returns the same verdict but leaves every stored register as it was.

Top module: `mmu_access_check`

## Requirements
- R1: After reset, rsp_valid is 0, reg_badaddr and reg_exception are 0, reg_tlbmisc_d is 0, reg_pteaddr holds PTBASE_INIT in bits [31:22] with zeros below, and req_ready is 1.
- R2: With mmu_present low, an aligned access returns rsp_ok=1, cause 0, and rsp_paddr equal to the address.
- R3: In privileged mode (req_super=1) an aligned address at or above 0xC0000000 returns rsp_ok=1 with rsp_paddr equal to the address, whatever the lookup; a privileged address between 0x80000000 and 0xBFFFFFFF goes through the lookup as usual.
- R4: In unprivileged mode an aligned address at or above 0x80000000, with mmu_present high, returns cause 11 (privileged-only region) regardless of the lookup.
- R5: On a lookup hit whose permission bits (bit 0 read, bit 1 write, bit 2 execute) grant the access type (req_type 0 load needs read, 1 store needs write, 2 or 3 fetch needs execute), rsp_ok=1 and rsp_paddr is the entry physical page (tlb_ppn) shifted up 12 bits plus the difference between the address page and tlb_vpn shifted up 12 bits plus address bits [11:0].
- R6: A lookup miss returns cause 12; a hit without the needed permission returns cause 13 for a load, 14 for a store and 15 for a fetch. rsp_ok is 1 exactly when the cause is 0.
- R7: On a committed translation fault (causes 12 to 15), reg_tlbmisc_d becomes 0 for a fetch and 1 for a load or store.
- R8: On a committed translation fault, reg_pteaddr keeps bits [31:22], takes address bits [31:12] into bits [21:2], and has bits [1:0] zero.
- R9: Every committed fault (causes 8, 11, 12 to 15) copies the request address into reg_badaddr; a granted access leaves it unchanged.
- R10: With req_probe high the response verdict and cause are given as usual but reg_badaddr, reg_pteaddr, reg_tlbmisc_d and reg_exception do not change.
- R11: A halfword access (req_size 1) with address bit 0 set, or a word access (req_size 2 or 3) with either of address bits [1:0] set, returns cause 8 before any other rule, and when committed sets reg_exception to 8 shifted into bits [6:2] (value 0x20) with all other bits zero; no other fault changes reg_exception.
- R12: rsp_valid is high exactly in the cycle after a cycle with req_valid high, and the response reflects that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Request accepted (always high) |
| req_addr | input | 32 | Virtual address |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_type | input | 2 | 0 load, 1 store, 2/3 fetch |
| req_super | input | 1 | Privileged mode |
| req_probe | input | 1 | Verdict only, no register update |
| mmu_present | input | 1 | Translation enabled |
| tlb_hit | input | 1 | Lookup found an entry |
| tlb_vpn | input | 20 | Entry virtual page |
| tlb_ppn | input | 20 | Entry physical page |
| tlb_perm | input | 3 | Entry permissions {exec, write, read} |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Access granted |
| rsp_paddr | output | 32 | Physical address when granted, else 0 |
| rsp_cause | output | 5 | Fault code, 0 when granted |
| reg_badaddr | output | 32 | Last faulting address |
| reg_pteaddr | output | 32 | Page-table base and faulting page pointer |
| reg_tlbmisc_d | output | 1 | Last translation fault was a data access |
| reg_exception | output | 32 | Cause register for misaligned faults |

## Verification
On every cycle the assertions check the response timing, the agreement between rsp_ok and a zero cause, that a probe never alters a stored register, that untranslated identity holds when translation is off, that unprivileged upper-half accesses always fault with code 11, and the exact misaligned cause-register value. The address arithmetic of a hit, the choice of permission fault per access type, the page pointer written into reg_pteaddr, the data/fetch flag and the priority of misalignment over the region rules are shown only by the bench's directed scenarios with known expected values.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;
   localparam logic [1:0] ACC_LOAD  = 2'd0;
   localparam logic [1:0] ACC_STORE = 2'd1;

   localparam logic [4:0] CAUSE_NONE      = 5'd0;
   localparam logic [4:0] CAUSE_UNALIGNED = 5'd8;
   localparam logic [4:0] CAUSE_SUPER     = 5'd11;
   localparam logic [4:0] CAUSE_TLB_MISS  = 5'd12;
   localparam logic [4:0] CAUSE_PERM_R    = 5'd13;
   localparam logic [4:0] CAUSE_PERM_W    = 5'd14;
   localparam logic [4:0] CAUSE_PERM_X    = 5'd15;

   function automatic logic is_fetch(input logic [1:0] t);
      return t[1];
   endfunction
endpackage

// File: rtl/mmu_align_chk.sv
module mmu_align_chk #(
   parameter int AW          = 32,
   parameter bit CHECK_ALIGN = 1'b1
) (
   input  logic [AW-1:0] addr,
   input  logic [1:0]    size,
   output logic          misaligned
);
   generate
      if (CHECK_ALIGN) begin : g_check
         always_comb begin
            case (size)
               2'd0:    misaligned = 1'b0;
               2'd1:    misaligned = addr[0];
               default: misaligned = |addr[1:0];
            endcase
         end
      end else begin : g_nocheck
         assign misaligned = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/mmu_region_class.sv
module mmu_region_class #(
   parameter int          AW          = 32,
   parameter logic [31:0] BYPASS_BASE = 32'hC000_0000,
   parameter logic [31:0] USER_LIMIT  = 32'h8000_0000
) (
   input  logic [AW-1:0] addr,
   input  logic          super_mode,
   input  logic          present,
   output logic          identity,
   output logic          user_viol
);
   localparam logic [AW-1:0] BYP = AW'(BYPASS_BASE);
   localparam logic [AW-1:0] ULIM = AW'(USER_LIMIT);

   generate
      if (BYPASS_BASE < USER_LIMIT) begin : g_bad_windows
         $error("bypass window must lie inside the privileged-only window");
      end
   endgenerate

   always_comb begin
      identity  = !present || (super_mode && addr >= BYP);
      user_viol = present && !super_mode && addr >= ULIM;
   end
endmodule

// File: rtl/mmu_tlb_judge.sv
module mmu_tlb_judge
   import mmu_chk_pkg::*;
#(
   parameter int AW        = 32,
   parameter int PAGE_BITS = 12
) (
   input  logic [AW-1:0]           addr,
   input  logic [1:0]              acc_type,
   input  logic                    hit,
   input  logic [AW-PAGE_BITS-1:0] vpn,
   input  logic [AW-PAGE_BITS-1:0] ppn,
   input  logic [2:0]              perm,
   output logic                    granted,
   output logic [AW-1:0]           paddr,
   output logic [4:0]              cause
);
   localparam int VPN_W = AW - PAGE_BITS;

   logic          need;
   logic [VPN_W-1:0] page_delta;

   always_comb begin
      if (is_fetch(acc_type))       need = perm[2];
      else if (acc_type == ACC_STORE) need = perm[1];
      else                            need = perm[0];

      granted    = hit && need;
      page_delta = addr[AW-1:PAGE_BITS] - vpn;
      paddr      = {ppn + page_delta, addr[PAGE_BITS-1:0]};

      if (!hit)                       cause = CAUSE_TLB_MISS;
      else if (need)                  cause = CAUSE_NONE;
      else if (is_fetch(acc_type))    cause = CAUSE_PERM_X;
      else if (acc_type == ACC_STORE) cause = CAUSE_PERM_W;
      else                            cause = CAUSE_PERM_R;
   end
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
   import mmu_chk_pkg::*;
#(
   parameter int          AW          = 32,
   parameter int          PAGE_BITS   = 12,
   parameter int unsigned PTBASE_INIT = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          commit,
   input  logic          set_bad,
   input  logic          set_tlb,
   input  logic          set_exc,
   input  logic          fetch,
   input  logic [AW-1:0] addr,
   output logic [AW-1:0] badaddr,
   output logic [AW-1:0] pteaddr,
   output logic          tlb_d,
   output logic [AW-1:0] exc
);
   localparam int VPN_W  = AW - PAGE_BITS;
   localparam int BASE_LO = VPN_W + 2;
   localparam int BASE_W  = AW - BASE_LO;

   generate
      if (BASE_W < 1) begin : g_bad_page
         $error("page size leaves no room for the table base field");
      end
   endgenerate

   logic [BASE_W-1:0] base_q;
   logic [VPN_W-1:0]  vpn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         badaddr <= '0;
         base_q  <= BASE_W'(PTBASE_INIT);
         vpn_q   <= '0;
         tlb_d   <= 1'b0;
         exc     <= '0;
      end else if (commit) begin
         if (set_bad) badaddr <= addr;
         if (set_tlb) begin
            vpn_q <= addr[AW-1:PAGE_BITS];
            tlb_d <= !fetch;
         end
         if (set_exc) exc <= AW'({CAUSE_UNALIGNED, 2'b00});
      end
   end

   assign pteaddr = {base_q, vpn_q, 2'b00};
endmodule

// File: rtl/mmu_access_check.sv
module mmu_access_check
   import mmu_chk_pkg::*;
#(
   parameter int          AW          = 32,
   parameter int          PAGE_BITS   = 12,
   parameter bit          CHECK_ALIGN = 1'b1,
   parameter int unsigned PTBASE_INIT = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [AW-1:0]           req_addr,
   input  logic [1:0]              req_size,
   input  logic [1:0]              req_type,
   input  logic                    req_super,
   input  logic                    req_probe,
   input  logic                    mmu_present,
   input  logic                    tlb_hit,
   input  logic [AW-PAGE_BITS-1:0] tlb_vpn,
   input  logic [AW-PAGE_BITS-1:0] tlb_ppn,
   input  logic [2:0]              tlb_perm,
   output logic                    rsp_valid,
   output logic                    rsp_ok,
   output logic [AW-1:0]           rsp_paddr,
   output logic [4:0]              rsp_cause,
   output logic [AW-1:0]           reg_badaddr,
   output logic [AW-1:0]           reg_pteaddr,
   output logic                    reg_tlbmisc_d,
   output logic [AW-1:0]           reg_exception
);
   generate
      if (AW != 32) begin : g_bad_aw
         $error("region windows assume a 32-bit address");
      end
      if (PAGE_BITS < 2 || PAGE_BITS >= AW - 2) begin : g_bad_pb
         $error("PAGE_BITS out of range");
      end
   endgenerate

   logic          misaligned, identity, user_viol, granted;
   logic [AW-1:0] xlate;
   logic [4:0]    tlb_cause;

   mmu_align_chk #(.AW(AW), .CHECK_ALIGN(CHECK_ALIGN)) u_align (
      .addr(req_addr), .size(req_size), .misaligned(misaligned));

   mmu_region_class #(.AW(AW)) u_region (
      .addr(req_addr), .super_mode(req_super), .present(mmu_present),
      .identity(identity), .user_viol(user_viol));

   mmu_tlb_judge #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_judge (
      .addr(req_addr), .acc_type(req_type), .hit(tlb_hit), .vpn(tlb_vpn),
      .ppn(tlb_ppn), .perm(tlb_perm), .granted(granted), .paddr(xlate),
      .cause(tlb_cause));

   logic          d_ok, f_bad, f_tlb, f_exc;
   logic [4:0]    d_cause;
   logic [AW-1:0] d_pa;

   always_comb begin
      d_ok = 1'b0; d_cause = CAUSE_NONE; d_pa = '0;
      f_bad = 1'b0; f_tlb = 1'b0; f_exc = 1'b0;
      if (misaligned) begin
         d_cause = CAUSE_UNALIGNED; f_bad = 1'b1; f_exc = 1'b1;
      end else if (identity) begin
         d_ok = 1'b1; d_pa = req_addr;
      end else if (user_viol) begin
         d_cause = CAUSE_SUPER; f_bad = 1'b1;
      end else if (granted) begin
         d_ok = 1'b1; d_pa = xlate;
      end else begin
         d_cause = tlb_cause; f_bad = 1'b1; f_tlb = 1'b1;
      end
   end

   mmu_fault_regs #(.AW(AW), .PAGE_BITS(PAGE_BITS), .PTBASE_INIT(PTBASE_INIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .commit(req_valid && !req_probe),
      .set_bad(f_bad), .set_tlb(f_tlb), .set_exc(f_exc),
      .fetch(is_fetch(req_type)), .addr(req_addr),
      .badaddr(reg_badaddr), .pteaddr(reg_pteaddr), .tlb_d(reg_tlbmisc_d),
      .exc(reg_exception));

   assign req_ready = 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_ok    <= 1'b0;
         rsp_paddr <= '0;
         rsp_cause <= CAUSE_NONE;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_ok    <= d_ok;
            rsp_paddr <= d_pa;
            rsp_cause <= d_cause;
         end
      end
   end

   assert_resp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_resp_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   assert_ok_iff_nocause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_ok == (rsp_cause == CAUSE_NONE)));
   assert_probe_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_probe) |=> ($stable(reg_badaddr) && $stable(reg_pteaddr)
                                    && $stable(reg_tlbmisc_d) && $stable(reg_exception)));
   assert_nommu_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mmu_present && !misaligned) |=> (rsp_ok && rsp_paddr == $past(req_addr)));
   assert_user_high_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mmu_present && !req_super && req_addr[AW-1] && !misaligned)
      |=> (rsp_cause == CAUSE_SUPER));
   assert_unaligned_exc_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_probe && misaligned) |=> (reg_exception == AW'(32'h20)));
endmodule

// File: tb/sim_mmu_access_check.sv
module sim_mmu_access_check;
   localparam int CLK_PERIOD = 10;
   localparam int unsigned PTB = 10'h2A5;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req_valid = 0, req_super = 0, req_probe = 0, mmu_present = 0, tlb_hit = 0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = 0, req_type = 0;
   logic [19:0] tlb_vpn = '0, tlb_ppn = '0;
   logic [2:0]  tlb_perm = '0;
   logic        req_ready, rsp_valid, rsp_ok, reg_tlbmisc_d;
   logic [31:0] rsp_paddr, reg_badaddr, reg_pteaddr, reg_exception;
   logic [4:0]  rsp_cause;

   int checks = 0, failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mmu_access_check #(.PTBASE_INIT(PTB)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size), .req_type(req_type),
      .req_super(req_super), .req_probe(req_probe), .mmu_present(mmu_present),
      .tlb_hit(tlb_hit), .tlb_vpn(tlb_vpn), .tlb_ppn(tlb_ppn), .tlb_perm(tlb_perm),
      .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_paddr(rsp_paddr),
      .rsp_cause(rsp_cause), .reg_badaddr(reg_badaddr), .reg_pteaddr(reg_pteaddr),
      .reg_tlbmisc_d(reg_tlbmisc_d), .reg_exception(reg_exception));

   task automatic chk(input bit cond, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
      chk(act === exp, req, what, act, exp);
   endtask

   // Drive one request on a falling edge; sample the response at the next falling edge.
   task automatic issue(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] ty,
                        input logic sup, input logic prb, input logic pres,
                        input logic hit, input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic [2:0] perm);
      @(negedge clk);
      req_valid = 1; req_addr = a; req_size = sz; req_type = ty; req_super = sup;
      req_probe = prb; mmu_present = pres; tlb_hit = hit; tlb_vpn = vpn;
      tlb_ppn = ppn; tlb_perm = perm;
      @(negedge clk);
      req_valid = 0;
      chk_eq("R12", "rsp_valid after request", {31'd0, rsp_valid}, 32'd1);
   endtask

   task automatic t_reset();
      chk_eq("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
      chk_eq("R1", "badaddr", reg_badaddr, 32'd0);
      chk_eq("R1", "pteaddr", reg_pteaddr, PTB << 22);
      chk_eq("R1", "tlb d", {31'd0, reg_tlbmisc_d}, 32'd0);
      chk_eq("R1", "exception", reg_exception, 32'd0);
      chk_eq("R1", "ready", {31'd0, req_ready}, 32'd1);
   endtask

   task automatic t_nommu();
      issue(32'h1234_5678, 2'd2, 2'd0, 0, 0, 0, 0, 20'h0, 20'h0, 3'b000);
      chk_eq("R2", "ok", {31'd0, rsp_ok}, 32'd1);
      chk_eq("R2", "paddr", rsp_paddr, 32'h1234_5678);
      chk_eq("R2", "cause", {27'd0, rsp_cause}, 32'd0);
      @(negedge clk);
      chk_eq("R12", "rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
   endtask

   task automatic t_bypass();
      issue(32'hC000_1234, 2'd2, 2'd2, 1, 0, 1, 0, 20'h0, 20'h0, 3'b000);
      chk_eq("R3", "bypass ok", {31'd0, rsp_ok}, 32'd1);
      chk_eq("R3", "bypass paddr", rsp_paddr, 32'hC000_1234);
      issue(32'h9000_0010, 2'd2, 2'd0, 1, 0, 1, 0, 20'h0, 20'h0, 3'b111);
      chk_eq("R3", "mid window goes to lookup", {27'd0, rsp_cause}, 32'd12);
   endtask

   task automatic t_user();
      issue(32'hC000_0004, 2'd2, 2'd0, 0, 0, 1, 1, 20'hC0000, 20'h00001, 3'b111);
      chk_eq("R4", "user high cause", {27'd0, rsp_cause}, 32'd11);
      chk_eq("R9", "badaddr user fault", reg_badaddr, 32'hC000_0004);
      chk_eq("R11", "exception untouched", reg_exception, 32'd0);
   endtask

   task automatic t_hit();
      issue(32'h0040_3ABC, 2'd0, 2'd0, 0, 0, 1, 1, 20'h00403, 20'h7F00A, 3'b001);
      chk_eq("R5", "load paddr", rsp_paddr, 32'h7F00_AABC);
      chk_eq("R5", "load ok", {31'd0, rsp_ok}, 32'd1);
      chk_eq("R9", "badaddr kept on grant", reg_badaddr, 32'hC000_0004);
      issue(32'h0040_3AB8, 2'd2, 2'd1, 0, 0, 1, 1, 20'h00403, 20'h00020, 3'b010);
      chk_eq("R5", "store paddr", rsp_paddr, 32'h0002_0AB8);
      issue(32'h0040_5100, 2'd2, 2'd2, 1, 0, 1, 1, 20'h00403, 20'h00100, 3'b100);
      chk_eq("R5", "fetch paddr with page delta", rsp_paddr, 32'h0010_2100);
   endtask

   task automatic t_perm();
      issue(32'h0040_3AB8, 2'd2, 2'd1, 0, 0, 1, 1, 20'h00403, 20'h00020, 3'b101);
      chk_eq("R6", "store perm cause", {27'd0, rsp_cause}, 32'd14);
      chk_eq("R6", "store perm ok", {31'd0, rsp_ok}, 32'd0);
      chk_eq("R7", "data d flag", {31'd0, reg_tlbmisc_d}, 32'd1);
      chk_eq("R8", "pteaddr store", reg_pteaddr, (PTB << 22) | (32'h00403 << 2));
      chk_eq("R9", "badaddr perm", reg_badaddr, 32'h0040_3AB8);
      issue(32'h1234_5000, 2'd2, 2'd2, 0, 0, 1, 1, 20'h12345, 20'h00020, 3'b011);
      chk_eq("R6", "fetch perm cause", {27'd0, rsp_cause}, 32'd15);
      chk_eq("R7", "fetch d flag", {31'd0, reg_tlbmisc_d}, 32'd0);
      chk_eq("R8", "pteaddr fetch", reg_pteaddr, (PTB << 22) | (32'h12345 << 2));
      issue(32'h0000_2000, 2'd2, 2'd0, 0, 0, 1, 1, 20'h00002, 20'h00020, 3'b110);
      chk_eq("R6", "load perm cause", {27'd0, rsp_cause}, 32'd13);
      issue(32'h7FFF_F000, 2'd0, 2'd3, 0, 0, 1, 0, 20'h0, 20'h0, 3'b111);
      chk_eq("R6", "miss cause", {27'd0, rsp_cause}, 32'd12);
      chk_eq("R7", "type 3 is fetch", {31'd0, reg_tlbmisc_d}, 32'd0);
      chk_eq("R8", "pteaddr miss", reg_pteaddr, (PTB << 22) | (32'h7FFFF << 2));
   endtask

   task automatic t_probe();
      issue(32'h0AB0_0000, 2'd2, 2'd1, 0, 1, 1, 0, 20'h0, 20'h0, 3'b000);
      chk_eq("R10", "probe cause", {27'd0, rsp_cause}, 32'd12);
      chk_eq("R10", "probe ok", {31'd0, rsp_ok}, 32'd0);
      chk_eq("R10", "probe badaddr", reg_badaddr, 32'h7FFF_F000);
      chk_eq("R10", "probe pteaddr", reg_pteaddr, (PTB << 22) | (32'h7FFFF << 2));
      chk_eq("R10", "probe d flag", {31'd0, reg_tlbmisc_d}, 32'd0);
      issue(32'h0000_0003, 2'd1, 2'd0, 0, 1, 1, 1, 20'h0, 20'h0, 3'b111);
      chk_eq("R10", "probe unaligned cause", {27'd0, rsp_cause}, 32'd8);
      chk_eq("R10", "probe exception", reg_exception, 32'd0);
   endtask

   task automatic t_align();
      issue(32'hC000_1001, 2'd1, 2'd1, 1, 0, 1, 1, 20'h0, 20'h0, 3'b111);
      chk_eq("R11", "half misaligned cause", {27'd0, rsp_cause}, 32'd8);
      chk_eq("R11", "exception value", reg_exception, 32'h0000_0020);
      chk_eq("R9", "badaddr unaligned", reg_badaddr, 32'hC000_1001);
      chk_eq("R11", "pteaddr untouched", reg_pteaddr, (PTB << 22) | (32'h7FFFF << 2));
      issue(32'h0000_0102, 2'd2, 2'd0, 0, 0, 0, 0, 20'h0, 20'h0, 3'b000);
      chk_eq("R11", "word misaligned no mmu", {27'd0, rsp_cause}, 32'd8);
      issue(32'h0000_0103, 2'd0, 2'd0, 0, 0, 0, 0, 20'h0, 20'h0, 3'b000);
      chk_eq("R11", "byte never misaligned", {31'd0, rsp_ok}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      t_nommu();
      t_bypass();
      t_user();
      t_hit();
      t_perm();
      t_probe();
      t_align();
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule